// File: doc/BRIEF.md
# Per-Channel Threshold and Fill-Level Monitor

This block watches the fill counts of a multi-channel FIFO. The counts come in as one packed vector, one field per channel. A single pair of thresholds covers every channel: one for almost-full and one for almost-empty. Both sit in registers behind a small memory-mapped configuration port, where they can be written and read back.

A second memory-mapped port reads the current fill level of the channel named by its address. A status output reports one channel per cycle. It carries the channel number and that channel's almost-full and almost-empty flags. The channel advances by one on every clock and wraps around, so a consumer that watches the status output can rebuild the flag state of every channel.

Top module: `fifo_level_monitor`

The status scan is built as a two-state machine. IDLE is the state held during reset. RUN is the state entered on the first clock after reset, and the machine stays in RUN until reset is asserted again. The status outputs are valid only in RUN.

## Requirements
- R1: After reset, the almost-full threshold is DEPTH-1 and the almost-empty threshold is 1. The read-data outputs of both ports are 0, and the status valid bit is low until the first clock edge after reset is released.
- R2: A write on the configuration port updates one threshold, and the new value takes effect at the next clock. Address 0 selects the almost-full threshold and address 1 selects the almost-empty threshold.
- R3: A configuration read returns the addressed threshold one cycle after the request. If a write hits the same register in the same cycle, the read returns the value held before that write. The read data holds its value in cycles with no read.
- R4: A fill-level read returns, one cycle later, the fill level of the channel selected by the address, as sampled in the request cycle. The read data holds its value in cycles with no read.
- R5: The first valid status reports channel 0. Each following cycle reports the next channel, and the count wraps to 0 after channel NCH-1.
- R6: The almost-full flag is 1 exactly when the reported channel's fill level is greater than or equal to the almost-full threshold. Both values are taken as they were at the clock edge that produced the status. A threshold written at that same edge is not yet used.
- R7: The almost-empty flag is 1 exactly when the reported channel's fill level is less than or equal to the almost-empty threshold. The same sampling rule as R6 applies.
- R8: The status valid bit stays high on every cycle from the first clock after reset until reset is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_levels | input | NCH*LVL_W | Packed fill counts; channel c occupies bits [c*LVL_W +: LVL_W] |
| cfg_wr | input | 1 | Threshold write strobe |
| cfg_rd | input | 1 | Threshold read strobe |
| cfg_addr | input | 1 | 0 = almost-full threshold, 1 = almost-empty threshold |
| cfg_wdata | input | LVL_W | Threshold write data |
| cfg_rdata | output | LVL_W | Threshold read data, one-cycle latency |
| lvl_rd | input | 1 | Fill-level read strobe |
| lvl_addr | input | CH_W | Channel selected for the fill-level read |
| lvl_rdata | output | LVL_W | Fill-level read data, one-cycle latency |
| stat_valid | output | 1 | Status valid |
| stat_chan | output | CH_W | Channel reported this cycle |
| stat_full | output | 1 | Almost-full flag for stat_chan |
| stat_empty | output | 1 | Almost-empty flag for stat_chan |

## Verification
Two events can land on the same clock edge:
- a threshold write, and the status comparison for whichever channel the scan has reached;
- a threshold write, and a configuration read of the same register.

The bench provokes both by issuing random writes while it reads on most cycles. It also holds the fill levels at one below, equal to and one above the current thresholds, so each compare sits on its boundary whenever a write coincides with it. A behavioural reference model judges every cycle, and that model always evaluates with the thresholds as they stood before the write.

// File: rtl/lvlmon_pkg.sv
`timescale 1ns/1ps
package lvlmon_pkg;
    typedef enum logic {
        SCAN_IDLE,
        SCAN_RUN
    } scan_state_t;

    localparam logic CFG_SEL_FULL  = 1'b0;
    localparam logic CFG_SEL_EMPTY = 1'b1;
endpackage

// File: rtl/lvlmon_regs.sv
`timescale 1ns/1ps
module lvlmon_regs #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic             cfg_addr,
    input  logic [LVL_W-1:0] cfg_wdata,
    output logic [LVL_W-1:0] cfg_rdata,
    output logic [LVL_W-1:0] thr_full,
    output logic [LVL_W-1:0] thr_empty
);
    import lvlmon_pkg::*;

    localparam logic [LVL_W-1:0] FULL_INIT  = LVL_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] EMPTY_INIT = LVL_W'(1);

    // Threshold registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_full  <= FULL_INIT;
            thr_empty <= EMPTY_INIT;
        end else if (cfg_wr) begin
            if (cfg_addr == CFG_SEL_FULL) thr_full  <= cfg_wdata;
            else                          thr_empty <= cfg_wdata;
        end
    end

    // Read data register; old value seen on same-edge write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= (cfg_addr == CFG_SEL_EMPTY) ? thr_empty : thr_full;
        end
    end
endmodule

// File: rtl/lvlmon_fill_rd.sv
`timescale 1ns/1ps
module lvlmon_fill_rd #(
    parameter int NCH   = 4,
    parameter int LVL_W = 7,
    parameter int CH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fill_arr [NCH],
    input  logic             lvl_rd,
    input  logic [CH_W-1:0]  lvl_addr,
    output logic [LVL_W-1:0] lvl_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_rdata <= '0;
        end else if (lvl_rd) begin
            lvl_rdata <= fill_arr[lvl_addr];
        end
    end
endmodule

// File: rtl/lvlmon_scan.sv
`timescale 1ns/1ps
module lvlmon_scan #(
    parameter int NCH   = 4,
    parameter int LVL_W = 7,
    parameter int CH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fill_arr [NCH],
    input  logic [LVL_W-1:0] thr_full,
    input  logic [LVL_W-1:0] thr_empty,
    output logic             stat_valid,
    output logic [CH_W-1:0]  stat_chan,
    output logic             stat_full,
    output logic             stat_empty
);
    import lvlmon_pkg::*;

    localparam logic [CH_W-1:0] PTR_LAST = CH_W'(NCH - 1);

    scan_state_t       state_q, state_d;
    logic [CH_W-1:0]   ptr_q;
    logic [LVL_W-1:0]  cur_fill;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: IDLE -> RUN on first clock, RUN holds
    always_comb begin
        unique case (state_q)
            SCAN_IDLE: state_d = SCAN_RUN;
            SCAN_RUN:  state_d = SCAN_RUN;
            default:   state_d = SCAN_IDLE;
        endcase
    end

    assign cur_fill   = fill_arr[ptr_q];
    assign stat_valid = (state_q == SCAN_RUN);

    // Outputs: rotating pointer and registered flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            stat_chan  <= '0;
            stat_full  <= 1'b0;
            stat_empty <= 1'b0;
        end else begin
            ptr_q      <= (ptr_q == PTR_LAST) ? '0 : ptr_q + CH_W'(1);
            stat_chan  <= ptr_q;
            stat_full  <= (cur_fill >= thr_full);
            stat_empty <= (cur_fill <= thr_empty);
        end
    end
endmodule

// File: rtl/fifo_level_monitor.sv
`timescale 1ns/1ps
module fifo_level_monitor #(
    parameter int NCH   = 4,
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1),
    parameter int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*LVL_W-1:0] fill_levels,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic                 cfg_addr,
    input  logic [LVL_W-1:0]     cfg_wdata,
    output logic [LVL_W-1:0]     cfg_rdata,
    input  logic                 lvl_rd,
    input  logic [CH_W-1:0]      lvl_addr,
    output logic [LVL_W-1:0]     lvl_rdata,
    output logic                 stat_valid,
    output logic [CH_W-1:0]      stat_chan,
    output logic                 stat_full,
    output logic                 stat_empty
);
    logic [LVL_W-1:0] fill_arr [NCH];
    logic [LVL_W-1:0] thr_full;
    logic [LVL_W-1:0] thr_empty;

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign fill_arr[g] = fill_levels[g*LVL_W +: LVL_W];
    end

    lvlmon_regs #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .thr_full(thr_full), .thr_empty(thr_empty)
    );

    lvlmon_fill_rd #(.NCH(NCH), .LVL_W(LVL_W), .CH_W(CH_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .fill_arr(fill_arr),
        .lvl_rd(lvl_rd), .lvl_addr(lvl_addr), .lvl_rdata(lvl_rdata)
    );

    lvlmon_scan #(.NCH(NCH), .LVL_W(LVL_W), .CH_W(CH_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .fill_arr(fill_arr),
        .thr_full(thr_full), .thr_empty(thr_empty),
        .stat_valid(stat_valid), .stat_chan(stat_chan),
        .stat_full(stat_full), .stat_empty(stat_empty)
    );
endmodule

// File: rtl/lvlmon_checker.sv
`timescale 1ns/1ps
module lvlmon_checker #(
    parameter int NCH   = 4,
    parameter int DEPTH = 64,
    parameter int LVL_W = 7,
    parameter int CH_W  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH*LVL_W-1:0] fill_levels,
    input logic                 cfg_wr,
    input logic                 cfg_rd,
    input logic                 cfg_addr,
    input logic [LVL_W-1:0]     cfg_wdata,
    input logic [LVL_W-1:0]     cfg_rdata,
    input logic                 lvl_rd,
    input logic [CH_W-1:0]      lvl_addr,
    input logic [LVL_W-1:0]     lvl_rdata,
    input logic                 stat_valid,
    input logic [CH_W-1:0]      stat_chan,
    input logic                 stat_full,
    input logic                 stat_empty
);
    logic [NCH*LVL_W-1:0] fill_q;
    logic [LVL_W-1:0]     shd_full, shd_empty;
    logic [LVL_W-1:0]     addr_fill, shown_fill;
    logic [CH_W-1:0]      next_chan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q    <= '0;
            shd_full  <= LVL_W'(DEPTH - 1);
            shd_empty <= LVL_W'(1);
        end else begin
            fill_q <= fill_levels;
            if (cfg_wr && !cfg_addr) shd_full  <= cfg_wdata;
            if (cfg_wr &&  cfg_addr) shd_empty <= cfg_wdata;
        end
    end

    always_comb begin
        addr_fill  = fill_levels[int'(lvl_addr)*LVL_W +: LVL_W];
        shown_fill = fill_q[int'(stat_chan)*LVL_W +: LVL_W];
    end

    assign next_chan = (int'(stat_chan) == NCH - 1) ? '0 : stat_chan + CH_W'(1);

    assert_first_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_valid) |-> stat_chan == '0);
    assert_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> stat_chan == $past(next_chan));
    assert_valid_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> stat_valid);
    assert_fill_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_rd |=> lvl_rdata == $past(addr_fill));
    assert_fill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_rd |=> $stable(lvl_rdata));
    assert_cfg_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rdata == $past(cfg_addr ? shd_empty : shd_full));
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata));
    assert_full_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> stat_full == (shown_fill >= $past(shd_full)));
    assert_empty_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> stat_empty == (shown_fill <= $past(shd_empty)));
endmodule

bind fifo_level_monitor lvlmon_checker #(
    .NCH(NCH), .DEPTH(DEPTH), .LVL_W(LVL_W), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_levels(fill_levels),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lvl_rd(lvl_rd), .lvl_addr(lvl_addr), .lvl_rdata(lvl_rdata),
    .stat_valid(stat_valid), .stat_chan(stat_chan),
    .stat_full(stat_full), .stat_empty(stat_empty)
);

// File: tb/sim_fifo_level_monitor.sv
`timescale 1ns/1ps
module sim_fifo_level_monitor;
    localparam int NCH    = 4;
    localparam int DEPTH  = 64;
    localparam int LVL_W  = 7;
    localparam int CH_W   = 2;
    localparam int CYCLES = 600;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH*LVL_W-1:0] fill_levels = '0;
    logic                 cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_addr = 1'b0;
    logic [LVL_W-1:0]     cfg_wdata = '0;
    logic [LVL_W-1:0]     cfg_rdata;
    logic                 lvl_rd = 1'b0;
    logic [CH_W-1:0]      lvl_addr = '0;
    logic [LVL_W-1:0]     lvl_rdata;
    logic                 stat_valid, stat_full, stat_empty;
    logic [CH_W-1:0]      stat_chan;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state
    int m_af = DEPTH - 1, m_ae = 1, m_ptr = 0;
    int fill_m [NCH];
    int e_cfg = 0, e_lvl = 0, e_chan = 0;
    bit e_valid = 0, e_full = 0, e_empty = 0;

    always #4 clk = ~clk;

    fifo_level_monitor #(.NCH(NCH), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .fill_levels(fill_levels),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lvl_rd(lvl_rd), .lvl_addr(lvl_addr), .lvl_rdata(lvl_rdata),
        .stat_valid(stat_valid), .stat_chan(stat_chan),
        .stat_full(stat_full), .stat_empty(stat_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int near(input int base, input int r);
        int v = base + (r % 3) - 1;
        if (v < 0) v = 0;
        if (v > DEPTH) v = DEPTH;
        return v;
    endfunction

    task automatic compare_all();
        chk(stat_valid == e_valid, "R8 valid", int'(stat_valid), int'(e_valid));
        chk(int'(stat_chan) == e_chan, "R5 chan", int'(stat_chan), e_chan);
        chk(stat_full == e_full, "R6 almost-full", int'(stat_full), int'(e_full));
        chk(stat_empty == e_empty, "R7 almost-empty", int'(stat_empty), int'(e_empty));
        chk(int'(cfg_rdata) == e_cfg, "R3/R2 cfg read", int'(cfg_rdata), e_cfg);
        chk(int'(lvl_rdata) == e_lvl, "R4 fill read", int'(lvl_rdata), e_lvl);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) fill_m[c] = 0;
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        chk(stat_valid == 1'b0, "R1 valid in reset", int'(stat_valid), 0);
        chk(cfg_rdata == '0, "R1 cfg_rdata in reset", int'(cfg_rdata), 0);
        chk(lvl_rdata == '0, "R1 lvl_rdata in reset", int'(lvl_rdata), 0);
        rst_n = 1'b1;
        for (int i = 0; i < CYCLES; i++) begin
            // drive inputs for the coming edge
            for (int c = 0; c < NCH; c++) begin
                int r = $urandom % 8;
                if (r < 3)      fill_m[c] = near(m_af, $urandom);
                else if (r < 6) fill_m[c] = near(m_ae, $urandom);
                else            fill_m[c] = $urandom % (DEPTH + 1);
                fill_levels[c*LVL_W +: LVL_W] = LVL_W'(fill_m[c]);
            end
            if (i < 2) begin
                // R1: default thresholds read back first
                cfg_rd = 1'b1; cfg_addr = (i == 1); cfg_wr = 1'b0;
            end else begin
                cfg_rd   = ($urandom % 4) != 0;
                cfg_addr = $urandom % 2;
                cfg_wr   = ($urandom % 5) == 0;
            end
            cfg_wdata = LVL_W'($urandom % (DEPTH + 1));
            lvl_rd    = ($urandom % 3) != 0;
            lvl_addr  = CH_W'($urandom % NCH);
            // predict state after the edge (old thresholds used)
            e_valid = 1;
            e_chan  = m_ptr;
            e_full  = fill_m[m_ptr] >= m_af;
            e_empty = fill_m[m_ptr] <= m_ae;
            if (cfg_rd) e_cfg = cfg_addr ? m_ae : m_af;
            if (lvl_rd) e_lvl = fill_m[int'(lvl_addr)];
            if (cfg_wr) begin
                if (cfg_addr) m_ae = int'(cfg_wdata);
                else          m_af = int'(cfg_wdata);
            end
            m_ptr = (m_ptr + 1) % NCH;
            @(negedge clk);
            compare_all();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule